// File: doc/BRIEF.md
# GPIO Output-Enable Set/Clear Register Block

This block controls four general-purpose pins from one 32-bit register word on a bus with per-byte write enables. The bus cannot write the output-driver enables directly. One byte lane takes write-1-to-set pulses and another takes write-1-to-clear pulses, so software can turn on or turn off the drivers of chosen pins without first reading the current state. A third lane holds the data values that enabled pins drive. The top byte returns the pin levels, sampled through one register stage.

Each pin is a separate input, output and output-enable signal, not a tristate pad. A disabled pin drives its output low and deasserts its enable, and its level is still visible through the input path. Byte enables are active-low. The asynchronous reset is released synchronously inside the block.

Top module: `gpio_setclr_regs`

## Requirements
- R1: While reset is asserted, and until the first write after it, all output enables are 0, the output data is 0, `pin_oe` is 0 and `pin_out` is 0.
- R2: A write with `wr_be_n[2]`=0 clears the output enable of every pin n whose bit 16+n is 1 (bits 19:16).
- R3: A write with `wr_be_n[3]`=0 sets the output enable of every pin n whose bit 20+n is 1 (bits 23:20).
- R4: Zero bits in the set or clear field do not change the enables. A write whose relevant byte enable is 1 leaves that field's effect out.
- R5: If one write sets and clears the same pin, that pin's enable ends at 0.
- R6: Read bits 19:16 and read bits 23:20 both return the current four-bit output-enable vector.
- R7: Read bits 31:28 return `pin_in` as registered at the previous clock edge, so a pin change shows one cycle later.
- R8: Read bits 27:24, 15:12 and 7:0 return 0. Writes to bits 31:24 or to byte 0 have no effect.
- R9: A write with `wr_be_n[1]`=0 loads bits 11:8 into the output data register, which reads back on bits 11:8.
- R10: `pin_oe` equals the enable vector. `pin_out[n]` is the data bit n when the enable of pin n is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register word |
| wr_be_n | input | 4 | Active-low byte enables, bit k for byte lane k |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the register word |
| pin_in | input | 4 | Pin input levels |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output-driver enables |

## Verification
The bench builds the block with its default parameters: four pins and a two-stage reset synchronizer. Four pins fill the set, clear, data and input nibbles completely, so a single write with all byte enables active can set, clear, load data and hit the reserved top byte at the same time. Two synchronizer stages make the release of reset two cycles long, and the bench waits for it before the first access. The stimulus table mixes set-only, clear-only, overlapping set and clear, disabled lanes and all-lane writes, which exercises clear priority and lane gating across every pin.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int DATA_W   = 32;
  localparam int LANE_W   = 8;
  localparam int BE_W     = DATA_W / LANE_W;
  localparam int NIB_W    = 4;
  // Byte lanes and field positions that the bus decodes
  localparam int LANE_DAT = 1;
  localparam int LANE_CLR = 2;
  localparam int LANE_SET = 3;
  localparam int DAT_LO   = LANE_DAT * LANE_W;
  localparam int CLR_LO   = LANE_CLR * LANE_W;
  localparam int SET_LO   = CLR_LO + NIB_W;
  localparam int PIN_LO   = LANE_SET * LANE_W + NIB_W;
endpackage

// File: rtl/gpio_sc_rst_sync.sv
module gpio_sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_sc_oe_reg.sv
module gpio_sc_oe_reg #(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [PIN_W-1:0] set_bits,
  input  logic [PIN_W-1:0] clr_bits,
  output logic [PIN_W-1:0] oe
);
  logic [PIN_W-1:0] oe_d;
  logic [PIN_W-1:0] set_m;
  logic [PIN_W-1:0] clr_m;
  logic             oe_en;

  always_comb begin
    set_m = set_we ? set_bits : '0;
    clr_m = clr_we ? clr_bits : '0;
    oe_en = set_we | clr_we;
    // clear wins over set on the same pin
    oe_d  = (oe | set_m) & ~clr_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oe <= '0;
    else if (oe_en) oe <= oe_d;
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((oe & $past(clr_bits)) == '0));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((oe & $past(set_bits)) == $past(set_bits)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(oe));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && clr_we) |=> ((oe & $past(clr_bits)) == '0));
endmodule

// File: rtl/gpio_sc_dout_reg.sv
module gpio_sc_dout_reg #(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_we,
  input  logic [PIN_W-1:0] dat_bits,
  output logic [PIN_W-1:0] dout
);
  logic [PIN_W-1:0] dout_d;

  always_comb begin
    dout_d = dat_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (dat_we) dout <= dout_d;
  end

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |=> (dout == $past(dat_bits)));

  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(dout));
endmodule

// File: rtl/gpio_sc_in_sync.sv
module gpio_sc_in_sync #(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_q
);
  logic [PIN_W-1:0] pin_d;

  always_comb begin
    pin_d = pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_q == $past(pin_in)));
endmodule

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs
  import gpio_sc_pkg::*;
#(
  parameter int PIN_W      = NIB_W,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic             rst_sync_n;
  logic             set_we;
  logic             clr_we;
  logic             dat_we;
  logic [PIN_W-1:0] oe;
  logic [PIN_W-1:0] dout;
  logic [PIN_W-1:0] pin_q;
  logic             unused_bits;

  assign set_we = wr_en & ~wr_be_n[LANE_SET];
  assign clr_we = wr_en & ~wr_be_n[LANE_CLR];
  assign dat_we = wr_en & ~wr_be_n[LANE_DAT];
  assign unused_bits = ^{wr_be_n[0], wr_data[DAT_LO-1:0],
                         wr_data[CLR_LO-1:DAT_LO+PIN_W],
                         wr_data[DATA_W-1:SET_LO+PIN_W]};

  gpio_sc_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  gpio_sc_oe_reg #(.PIN_W(PIN_W)) i_oe_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .set_bits (wr_data[SET_LO +: PIN_W]),
    .clr_bits (wr_data[CLR_LO +: PIN_W]),
    .oe       (oe)
  );

  gpio_sc_dout_reg #(.PIN_W(PIN_W)) i_dout_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dat_we   (dat_we),
    .dat_bits (wr_data[DAT_LO +: PIN_W]),
    .dout     (dout)
  );

  gpio_sc_in_sync #(.PIN_W(PIN_W)) i_in_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in),
    .pin_q  (pin_q)
  );

  always_comb begin
    rd_data = '0;
    rd_data[DAT_LO +: PIN_W] = dout;
    rd_data[CLR_LO +: PIN_W] = oe;
    rd_data[SET_LO +: PIN_W] = oe;
    rd_data[PIN_LO +: PIN_W] = pin_q;
  end

  genvar g;
  generate
    for (g = 0; g < PIN_W; g++) begin : g_pin
      assign pin_oe[g]  = oe[g];
      assign pin_out[g] = oe[g] ? dout[g] : 1'b0;
    end
  endgenerate

  assert_rd_matches_oe_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rd_data[SET_LO +: PIN_W] == pin_oe));
endmodule

// File: tb/test_gpio_setclr_regs.sv
module test_gpio_setclr_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be_n;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pin_in;
  logic [3:0]  pin_out;
  logic [3:0]  pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_setclr_regs i_gpio_setclr_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be_n(wr_be_n),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {be_n, wdata, expected enables, expected data}
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {4'b0111, 32'h00F0_0000, 4'hF, 4'h0},  // R3 set all
    {4'b1011, 32'h0005_0000, 4'hA, 4'h0},  // R2 clear pins 0,2
    {4'b1101, 32'h0000_0900, 4'hA, 4'h9},  // R9 data load
    {4'b0011, 32'h0000_0000, 4'hA, 4'h9},  // R4 zero bits
    {4'b1111, 32'h00FF_0F00, 4'hA, 4'h9},  // R4 lanes off
    {4'b0011, 32'h0035_0000, 4'hA, 4'h9},  // R5 pin0 set+clear
    {4'b0111, 32'h0050_0000, 4'hF, 4'h9},  // R3 set pins 0,2
    {4'b0000, 32'hFF3C_0600, 4'h3, 4'h6}   // R5 R8 all lanes
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be_n = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be_n = 4'hF; wr_data = '0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_be_n = 4'hF; wr_data = '0; pin_in = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {28'd0, pin_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 read after reset", rd_data, 32'h0);
    check("R1 pins after reset", {24'd0, pin_oe, pin_out}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      write(VEC[i][43:40], VEC[i][39:8]);
      check($sformatf("R2 R3 enable vec%0d", i), {28'd0, pin_oe}, {28'd0, VEC[i][7:4]});
      check($sformatf("R6 read fields vec%0d", i), {24'd0, rd_data[23:16]},
            {24'd0, VEC[i][7:4], VEC[i][7:4]});
      check($sformatf("R9 data vec%0d", i), {28'd0, rd_data[11:8]}, {28'd0, VEC[i][3:0]});
      check($sformatf("R10 pin_out vec%0d", i), {28'd0, pin_out},
            {28'd0, VEC[i][3:0] & VEC[i][7:4]});
      check($sformatf("R8 zero bits vec%0d", i), {rd_data[27:24], rd_data[15:12], rd_data[7:0]}, 16'h0);
    end

    // R7 input path: one-cycle latency
    @(negedge clk);
    pin_in = 4'h5;
    #1;
    check("R7 not yet visible", {28'd0, rd_data[31:28]}, 32'h0);
    @(negedge clk);
    check("R7 visible next cycle", {28'd0, rd_data[31:28]}, 32'h5);
    pin_in = 4'hF;
    @(negedge clk);
    check("R7 all high", {28'd0, rd_data[31:28]}, 32'hF);

    // R5 R8: everything written at once
    write(4'b0000, 32'hFFFF_FFFF);
    check("R5 enables after set+clear all", {28'd0, pin_oe}, 32'h0);
    check("R8 reserved and unused zero", {rd_data[27:24], rd_data[15:12], rd_data[7:0]}, 16'h0);
    check("R8 input unaffected by write", {28'd0, rd_data[31:28]}, 32'hF);
    check("R9 data all ones", {28'd0, rd_data[11:8]}, 32'hF);
    check("R10 disabled drives low", {28'd0, pin_out}, 32'h0);

    // R3 R10 enable pin 1 only
    write(4'b0111, 32'h0020_0000);
    check("R10 single pin", {24'd0, pin_oe, pin_out}, {24'd0, 4'h2, 4'h2});

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {24'd0, pin_oe, pin_out}, 32'h0);
    check("R1 read in reset", rd_data[23:0], 24'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule